// File: doc/BRIEF.md
# Front-End Time-Sample Packer

This block turns one time sample of a 96-channel front end into a stream of 100 sixteen-bit words. The inputs are six layers of sixteen channels, each with a 13-bit ADC value and an active-low overlap flag. A 16-bit event information word is also given and is spread one bit per channel group across the sample. The 96 data words are emitted in a fixed, non-sequential channel and layer order. They are followed by a CRC word over their ADC bits, two pipeline status words and a constant filler word.

The producer presents one sample at a time with `smp_valid` and holds all sample inputs stable until `smp_ready` pulses. That pulse coincides with the acceptance of the sample's last word. The consumer takes words with an `out_valid`/`out_ready` handshake. An event is 16 samples when information bit 15 is 1 and 8 samples when it is 0. `out_last` marks the final word of the event.

Top module: `sample_packer`

## Requirements
- R1: After reset, `out_valid` is low while `smp_valid` is low. The first word offered is the data word of layer 3, channel 0 of the first sample.
- R2: ADC element e = (L-1)*16 + c (layer L in 1..6, channel c in 0..15) sits at `adc_flat[e*13 +: 13]`, and its overlap flag is at `ovl_n[e]`. A data word is {0, ovl_n[e], info bit, adc}, with bit 15 at 0, bit 14 the flag and bits [12:0] the ADC value.
- R3: The six words of a channel group visit layers in the order 3, 1, 5, 6, 4, 2.
- R4: Group k (k = 0..15) carries channel k XOR (k>>1), giving the order 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8.
- R5: Bit 13 of every word in group k equals `info[k]`.
- R6: Word 97 is {0, crc}. The crc is a 15-bit CRC with polynomial x^15+x+1 over the low 13 bits of words 1..96, taken MSB first and starting from zero for every sample.
- R7: Word 98 is {0111, l1a_empty, trg_empty, l1a_full, trg_full, trg_len[3:0], free_blks[3:0]}.
- R8: Word 99 is {0111, busy, ovwr_err, push, trg_pop, l1a_len[7:0]}.
- R9: Word 100 is 0x7FFF.
- R10: `smp_ready` is high exactly in the cycle word 100 is accepted. While `out_ready` is low, the offered word does not change.
- R11: `out_last` is high on word 100 of sample 16 when `info[15]`=1, and on word 100 of sample 8 when `info[15]`=0. It is low on every other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample inputs are present and held |
| smp_ready | output | 1 | Sample fully emitted this cycle |
| adc_flat | input | 1248 | 96 ADC values, 13 bits each |
| ovl_n | input | 96 | Active-low overlap flag per element |
| info | input | 16 | Event information word |
| free_blks | input | 4 | Free capacitor block count |
| trg_len | input | 4 | Trigger pipeline length |
| trg_full | input | 1 | Trigger pipeline full |
| l1a_full | input | 1 | Accept pipeline full |
| trg_empty | input | 1 | Trigger pipeline empty |
| l1a_empty | input | 1 | Accept pipeline empty |
| l1a_len | input | 8 | Accept pipeline length |
| trg_pop | input | 1 | Trigger pipeline pop |
| push | input | 1 | Data push flag |
| ovwr_err | input | 1 | Overwrite error |
| busy | input | 1 | System busy |
| out_valid | output | 1 | Word offered |
| out_ready | input | 1 | Consumer takes word |
| out_word | output | 16 | Output word |
| out_last | output | 1 | Last word of event |

## Verification
The CRC clear and the sample/event wrap fall in the same cycle: acceptance of word 100 must zero the CRC, rewind the word position and, on the final sample, also rewind the sample count. The bench makes this happen under a repeating ready pattern that stalls the consumer just around the wrap. It then checks that the next sample's CRC word matches a model started from zero and that `out_last` appears only at the right sample count for both event lengths. A wrong clear or a wrong wrap both show up as a CRC or framing mismatch in the following sample.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int N_INFO = 4;

  // Channel carried by group k: reflected binary order
  function automatic logic [3:0] grp_chan(input logic [3:0] k);
    return k ^ (k >> 1);
  endfunction

  // Layer (1..6) carried by position p within a group
  function automatic logic [2:0] pos_layer(input logic [2:0] p);
    case (p)
      3'd0:    return 3'd3;
      3'd1:    return 3'd1;
      3'd2:    return 3'd5;
      3'd3:    return 3'd6;
      3'd4:    return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/sp_seq.sv
module sp_seq #(
  parameter int N_LAYER = 6,
  parameter int N_GRP   = 16,
  parameter int N_SMP   = 16,
  localparam int N_DATA = N_LAYER * N_GRP,
  localparam int N_WORD = N_DATA + sp_pkg::N_INFO,
  localparam int IDX_W  = $clog2(N_WORD),
  localparam int LAY_W  = $clog2(N_LAYER),
  localparam int GRP_W  = $clog2(N_GRP),
  localparam int SMP_W  = $clog2(N_SMP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             long_evt,
  output logic [IDX_W-1:0] widx,
  output logic [LAY_W-1:0] lay,
  output logic [GRP_W-1:0] grp,
  output logic             is_data,
  output logic             wrap,
  output logic             evt_end
);
  logic [IDX_W-1:0] widx_q, widx_d;
  logic [LAY_W-1:0] lay_q, lay_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic [SMP_W-1:0] smp_top;

  always_comb begin
    smp_top = long_evt ? SMP_W'(N_SMP - 1) : SMP_W'(N_SMP / 2 - 1);
    wrap    = (widx_q == IDX_W'(N_WORD - 1));
    is_data = (widx_q < IDX_W'(N_DATA));
    evt_end = (smp_q == smp_top);
    widx_d = widx_q;
    lay_d  = lay_q;
    grp_d  = grp_q;
    smp_d  = smp_q;
    if (fire) begin
      if (wrap) begin
        widx_d = '0;
        lay_d  = '0;
        grp_d  = '0;
        smp_d  = evt_end ? '0 : smp_q + 1'b1;
      end else begin
        widx_d = widx_q + 1'b1;
        if (lay_q == LAY_W'(N_LAYER - 1)) begin
          lay_d = '0;
          grp_d = grp_q + 1'b1;
        end else begin
          lay_d = lay_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      lay_q  <= '0;
      grp_q  <= '0;
      smp_q  <= '0;
    end else if (fire) begin
      widx_q <= widx_d;
      lay_q  <= lay_d;
      grp_q  <= grp_d;
      smp_q  <= smp_d;
    end
  end

  assign widx = widx_q;
  assign lay  = lay_q;
  assign grp  = grp_q;

  p_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q < IDX_W'(N_WORD));
  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wrap) |=> (widx_q == '0 && lay_q == '0 && grp_q == '0));
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(widx_q));
endmodule

// File: rtl/sp_crc.sv
module sp_crc #(
  parameter int             DATA_W = 13,
  parameter int             CRC_W  = 15,
  parameter logic [CRC_W-1:0] POLY = 15'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_q;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ din[b];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_d = clr ? '0 : c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= '0;
    else if (en || clr)  crc_q <= crc_d;
  end

  assign crc = crc_q;

  p_crc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == '0));
  p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(crc_q));
endmodule

// File: rtl/sp_fmt.sv
module sp_fmt #(
  parameter int N_LAYER = 6,
  parameter int N_GRP   = 16,
  parameter int ADC_W   = 13,
  parameter int CRC_W   = 15,
  localparam int N_DATA = N_LAYER * N_GRP,
  localparam int N_WORD = N_DATA + sp_pkg::N_INFO,
  localparam int IDX_W  = $clog2(N_WORD),
  localparam int LAY_W  = $clog2(N_LAYER),
  localparam int GRP_W  = $clog2(N_GRP)
) (
  input  logic [IDX_W-1:0]        widx,
  input  logic [LAY_W-1:0]        lay,
  input  logic [GRP_W-1:0]        grp,
  input  logic [N_DATA*ADC_W-1:0] adc_flat,
  input  logic [N_DATA-1:0]       ovl_n,
  input  logic [N_GRP-1:0]        info,
  input  logic [CRC_W-1:0]        crc,
  input  logic [11:0]             stat_a,
  input  logic [11:0]             stat_b,
  output logic [15:0]             word,
  output logic [ADC_W-1:0]        adc_sel
);
  localparam int EL_W = $clog2(N_DATA);
  logic [EL_W-1:0] elem;
  logic [2:0]      lyr;
  logic [3:0]      chn;

  always_comb begin
    lyr     = sp_pkg::pos_layer(3'(lay));
    chn     = sp_pkg::grp_chan(4'(grp));
    elem    = EL_W'((int'(lyr) - 1) * N_GRP + int'(chn));
    adc_sel = adc_flat[int'(elem)*ADC_W +: ADC_W];
    if (widx < IDX_W'(N_DATA))
      word = {1'b0, ovl_n[elem], info[grp], adc_sel};
    else if (widx == IDX_W'(N_DATA))
      word = {1'b0, crc};
    else if (widx == IDX_W'(N_DATA + 1))
      word = {4'b0111, stat_a};
    else if (widx == IDX_W'(N_DATA + 2))
      word = {4'b0111, stat_b};
    else
      word = 16'h7FFF;
  end
endmodule

// File: rtl/sample_packer.sv
module sample_packer #(
  parameter int N_LAYER = 6,
  parameter int N_GRP   = 16,
  parameter int ADC_W   = 13,
  parameter int CRC_W   = 15,
  parameter int N_SMP   = 16,
  localparam int N_DATA = N_LAYER * N_GRP,
  localparam int N_WORD = N_DATA + sp_pkg::N_INFO,
  localparam int IDX_W  = $clog2(N_WORD),
  localparam int LAY_W  = $clog2(N_LAYER),
  localparam int GRP_W  = $clog2(N_GRP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [N_DATA*ADC_W-1:0] adc_flat,
  input  logic [N_DATA-1:0]       ovl_n,
  input  logic [N_GRP-1:0]        info,
  input  logic [3:0]              free_blks,
  input  logic [3:0]              trg_len,
  input  logic                    trg_full,
  input  logic                    l1a_full,
  input  logic                    trg_empty,
  input  logic                    l1a_empty,
  input  logic [7:0]              l1a_len,
  input  logic                    trg_pop,
  input  logic                    push,
  input  logic                    ovwr_err,
  input  logic                    busy,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [15:0]             out_word,
  output logic                    out_last
);
  logic             rst_m, rst_s;
  logic             fire, wrap, evt_end, is_data;
  logic [IDX_W-1:0] widx;
  logic [LAY_W-1:0] lay;
  logic [GRP_W-1:0] grp;
  logic [CRC_W-1:0] crc;
  logic [ADC_W-1:0] adc_sel;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign out_valid = smp_valid & rst_s;
  assign fire      = out_valid & out_ready;
  assign smp_ready = fire & wrap;
  assign out_last  = out_valid & wrap & evt_end;

  sp_seq #(.N_LAYER(N_LAYER), .N_GRP(N_GRP), .N_SMP(N_SMP)) u_seq (
    .clk(clk), .rst_n(rst_s), .fire(fire), .long_evt(info[N_GRP-1]),
    .widx(widx), .lay(lay), .grp(grp), .is_data(is_data),
    .wrap(wrap), .evt_end(evt_end)
  );

  sp_crc #(.DATA_W(ADC_W), .CRC_W(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_s), .en(fire & is_data), .clr(fire & wrap),
    .din(adc_sel), .crc(crc)
  );

  sp_fmt #(.N_LAYER(N_LAYER), .N_GRP(N_GRP), .ADC_W(ADC_W), .CRC_W(CRC_W)) u_fmt (
    .widx(widx), .lay(lay), .grp(grp), .adc_flat(adc_flat), .ovl_n(ovl_n),
    .info(info), .crc(crc),
    .stat_a({l1a_empty, trg_empty, l1a_full, trg_full, trg_len, free_blks}),
    .stat_b({busy, ovwr_err, push, trg_pop, l1a_len}),
    .word(out_word), .adc_sel(adc_sel)
  );

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !smp_valid |-> !out_valid);
  p_dummy_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && wrap) |-> (out_word == 16'h7FFF));
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_s)
    smp_ready |=> (widx == '0));
  p_last_r11: assert property (@(posedge clk) disable iff (!rst_s)
    out_last |-> (out_word == 16'h7FFF));
endmodule

// File: tb/test_sample_packer.sv
module test_sample_packer;
  localparam int CLK_P = 10;
  localparam int ND    = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [1247:0] adc_flat = '0;
  logic [95:0]   ovl_n = '0;
  logic [15:0]   info = '0;
  logic [3:0]    free_blks = '0, trg_len = '0;
  logic          trg_full = 1'b0, l1a_full = 1'b0, trg_empty = 1'b0, l1a_empty = 1'b0;
  logic [7:0]    l1a_len = '0;
  logic          trg_pop = 1'b0, push = 1'b0, ovwr_err = 1'b0, busy = 1'b0;
  logic          out_valid, out_ready = 1'b0, out_last;
  logic [15:0]   out_word;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [15:0] exp_w [100];

  always #(CLK_P/2) clk = ~clk;

  sample_packer i_sample_packer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .adc_flat(adc_flat), .ovl_n(ovl_n), .info(info), .free_blks(free_blks),
    .trg_len(trg_len), .trg_full(trg_full), .l1a_full(l1a_full),
    .trg_empty(trg_empty), .l1a_empty(l1a_empty), .l1a_len(l1a_len),
    .trg_pop(trg_pop), .push(push), .ovwr_err(ovwr_err), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int layer_at(input int p);
    int t [6] = '{3, 1, 5, 6, 4, 2};
    return t[p];
  endfunction

  function automatic int chan_at(input int k);
    int t [16] = '{0, 1, 3, 2, 6, 7, 5, 4, 12, 13, 15, 14, 10, 11, 9, 8};
    return t[k];
  endfunction

  // CRC x^15+x+1, MSB first over 13 bits
  function automatic logic [14:0] crc_upd(input logic [14:0] c, input logic [12:0] d);
    logic [14:0] r = c;
    for (int b = 12; b >= 0; b--) begin
      if (r[14] ^ d[b]) r = {r[13:0], 1'b0} ^ 15'h0003;
      else              r = {r[13:0], 1'b0};
    end
    return r;
  endfunction

  task automatic load(input int ev, input int s, input bit long_m);
    logic [14:0] c = '0;
    for (int e = 0; e < ND; e++) begin
      adc_flat[e*13 +: 13] = (ev == 2) ? 13'h1FFF : 13'((e * 37 + s * 101 + ev * 7) & 13'h1FFF);
      ovl_n[e] = (ev == 2) ? 1'b1 : 1'(((e * 5 + s + ev) % 3) == 0);
    end
    info = {long_m, 15'((s * 2731 + ev * 977 + 16'h12A5) & 16'h7FFF)};
    free_blks = 4'((s + ev) % 13);
    trg_len = 4'(s * 3 + 1);
    {l1a_empty, trg_empty, l1a_full, trg_full} = 4'(s + ev);
    l1a_len = 8'(s * 17 + ev);
    {busy, ovwr_err, push, trg_pop} = 4'(15 - s);
    for (int w = 0; w < ND; w++) begin
      int g = w / 6;
      int e = (layer_at(w % 6) - 1) * 16 + chan_at(g);
      logic [12:0] a = adc_flat[e*13 +: 13];
      exp_w[w] = {1'b0, ovl_n[e], info[g], a};
      c = crc_upd(c, a);
    end
    exp_w[96] = {1'b0, c};
    exp_w[97] = {4'b0111, l1a_empty, trg_empty, l1a_full, trg_full, trg_len, free_blks};
    exp_w[98] = {4'b0111, busy, ovwr_err, push, trg_pop, l1a_len};
    exp_w[99] = 16'h7FFF;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_event(input int ev, input bit long_m);
    int ns = long_m ? 16 : 8;
    for (int s = 0; s < ns; s++) begin
      load(ev, s, long_m);
      smp_valid = 1'b1;
      for (int w = 0; w < 100; w++) begin
        bit taken = 1'b0;
        while (!taken) begin
          @(negedge clk);
          cyc++;
          out_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
          #1;
          if (w == 0 && s == 0)
            chk(out_word == exp_w[0], "R1 first word", out_word, exp_w[0]);
          else if (w < 96)
            chk(out_word == exp_w[w], "R2 R3 R4 R5 data word", out_word, exp_w[w]);
          else if (w == 96)
            chk(out_word == exp_w[w], "R6 crc word", out_word, exp_w[w]);
          else if (w == 97)
            chk(out_word == exp_w[w], "R7 status word", out_word, exp_w[w]);
          else if (w == 98)
            chk(out_word == exp_w[w], "R8 status word", out_word, exp_w[w]);
          else
            chk(out_word == exp_w[w], "R9 filler word", out_word, exp_w[w]);
          chk(smp_ready == (out_ready && w == 99), "R10 sample done",
              16'(smp_ready), 16'(out_ready && w == 99));
          chk(out_last == (w == 99 && s == ns - 1), "R11 event end",
              16'(out_last), 16'(w == 99 && s == ns - 1));
          taken = out_ready;
        end
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(out_valid == 1'b0, "R1 reset idle", 16'(out_valid), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(out_valid == 1'b0, "R1 idle without sample", 16'(out_valid), 16'd0);
    run_event(0, 1'b1);
    run_event(1, 1'b0);
    run_event(2, 1'b1);
    run_event(3, 1'b0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end
endmodule